// File: doc/BRIEF.md
# Packed 16-bit Multiply Unit

This block multiplies two 64-bit operands lane by lane. Each operand holds four signed 16-bit lanes, and the four 16x16 multipliers are shared by three operations. The high-half operation keeps the upper half of each 32-bit product. The low-half operation keeps the lower half. The pairwise-accumulate operation adds neighbouring products to form two 32-bit sums.

A 16-bit opcode arrives with each operand pair. Its upper byte must be the prefix 0x0F, and its lower byte picks the operation. The unit has two pipeline stages. The first stage registers the four products. The second stage registers the result that the operation selects. Data moves through a valid/ready handshake, and the whole pipe stops while a result waits at the output. An opcode the unit does not know is consumed and reported with a one-cycle pulse, and no result is produced for it. The unit produces no condition flags.

Top module: `pmu_top`

## Requirements
- R1: An opcode of 0x0FE5 (upper byte 0x0F, lower byte 0xE5) selects the high-half operation. Each 16-bit result lane i (bits 16i+15:16i) holds bits [31:16] of the signed product of lane i of a_i and lane i of b_i.
- R2: An opcode of 0x0FD5 selects the low-half operation. Each result lane holds bits [15:0] of the lane product, and this value is the same whether the lanes are read as signed or as unsigned.
- R3: An opcode of 0x0FF5 selects the pairwise-accumulate operation. Result bits [31:0] are the sum of the signed products of lanes 0 and 1, and bits [63:32] are the sum of the signed products of lanes 2 and 3. Each sum is taken modulo 2^32 and does not saturate.
- R4: In the accumulate operation, when every lane of both operands is 0x8000, each 32-bit half of the result is 0x80000000. This is the only input that overflows.
- R5: An opcode whose upper byte is not 0x0F, or whose lower byte is not one of 0xE5, 0xD5 or 0xF5, is accepted. It raises illegal_o for exactly one cycle, starting one cycle after acceptance, and it never produces out_valid_o.
- R6: If the output is not stalled, out_valid_o rises two clock cycles after a legal operand pair is accepted.
- R7: While out_valid_o is high and out_ready_i is low, out_valid_o and out_data_o hold their values and in_ready_o is low.
- R8: After reset, out_valid_o and illegal_o are low and in_ready_o is high.
- R9: While out_ready_i stays high, a new operand pair is accepted on every cycle. Results leave in the order the pairs were accepted, at a rate of one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An operand pair is offered |
| in_ready_o | output | 1 | The unit can take an operand pair |
| opc_i | input | 16 | Prefix byte in [15:8], operation byte in [7:0] |
| a_i | input | 64 | First operand, four 16-bit lanes |
| b_i | input | 64 | Second operand, four 16-bit lanes |
| out_valid_o | output | 1 | A result is present |
| out_ready_i | input | 1 | The consumer takes the result |
| out_data_o | output | 64 | Result |
| illegal_o | output | 1 | One-cycle pulse for a rejected opcode |

## Verification
The assertions check on every cycle that a stalled output holds its value, that ready is low during a stall, that the pipe moves by exactly one stage per cycle, that a rejected opcode never fills the first stage, and that the all-0x8000 accumulate case produces 0x80000000 in both halves. The arithmetic of each operation over arbitrary lane values can be shown only by the bench's scenarios. The same holds for the opcode mapping, result order under back-to-back traffic, and the agreement of the low-half result with an unsigned product. The bench compares these against its own lane model.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  typedef enum logic [1:0] {
    OP_HI  = 2'd0,
    OP_LO  = 2'd1,
    OP_MAC = 2'd2
  } pmu_op_e;

  localparam logic [7:0] OPC_PREFIX = 8'h0F;
  localparam logic [7:0] OPC_HI     = 8'hE5;
  localparam logic [7:0] OPC_LO     = 8'hD5;
  localparam logic [7:0] OPC_MAC    = 8'hF5;
endpackage

// File: rtl/pmu_decode.sv
module pmu_decode
  import pmu_pkg::*;
(
  input  logic [15:0] opc_i,
  output logic        legal_o,
  output pmu_op_e     op_o
);
  always_comb begin
    legal_o = (opc_i[15:8] == OPC_PREFIX);
    op_o    = OP_HI;
    unique case (opc_i[7:0])
      OPC_HI:  op_o = OP_HI;
      OPC_LO:  op_o = OP_LO;
      OPC_MAC: op_o = OP_MAC;
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmu_mul_stage.sv
module pmu_mul_stage
  import pmu_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LW    = 16,
  localparam int DW   = LANES * LW,
  localparam int PW   = 2 * LW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  load_i,
  input  pmu_op_e               op_i,
  input  logic [DW-1:0]         a_i,
  input  logic [DW-1:0]         b_i,
  output logic                  valid_o,
  output pmu_op_e               op_o,
  output logic [LANES*PW-1:0]   prod_o
);
  logic [LANES*PW-1:0] prod_d;

  // signed products only; low half equals the unsigned low half
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [LW-1:0] la, lb;
    assign la = a_i[l*LW +: LW];
    assign lb = b_i[l*LW +: LW];
    assign prod_d[l*PW +: PW] = PW'(la * lb);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      op_o    <= OP_HI;
      prod_o  <= '0;
    end else if (en_i) begin
      valid_o <= load_i;
      if (load_i) begin
        op_o   <= op_i;
        prod_o <= prod_d;
      end
    end
  end

  a_r7_s1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(valid_o) && $stable(prod_o));
endmodule

// File: rtl/pmu_result_stage.sv
module pmu_result_stage
  import pmu_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LW    = 16,
  localparam int DW   = LANES * LW,
  localparam int PW   = 2 * LW,
  localparam int NPAIR = LANES / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                valid_i,
  input  pmu_op_e             op_i,
  input  logic [LANES*PW-1:0] prod_i,
  output logic                valid_o,
  output logic [DW-1:0]       data_o
);
  logic [DW-1:0] hi_w, lo_w, mac_w, res_d;

  for (genvar l = 0; l < LANES; l++) begin : g_half
    assign hi_w[l*LW +: LW] = prod_i[l*PW + LW +: LW];
    assign lo_w[l*LW +: LW] = prod_i[l*PW +: LW];
  end

  // wrapping pairwise sum, no saturation
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign mac_w[p*PW +: PW] = prod_i[2*p*PW +: PW] + prod_i[(2*p+1)*PW +: PW];
  end

  always_comb begin
    unique case (op_i)
      OP_LO:   res_d = lo_w;
      OP_MAC:  res_d = mac_w;
      default: res_d = hi_w;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      if (valid_i) data_o <= res_d;
    end
  end

  a_r4_mac_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && valid_i && op_i == OP_MAC && prod_i == {LANES{PW'(1) << (PW-2)}}
    |=> data_o == {NPAIR{PW'(1) << (PW-1)}});
endmodule

// File: rtl/pmu_top.sv
module pmu_top
  import pmu_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LW    = 16,
  localparam int DW   = LANES * LW,
  localparam int PW   = 2 * LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [15:0]   opc_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o,
  output logic          illegal_o
);
  logic                legal, accept, adv, s1_valid;
  pmu_op_e             dec_op, s1_op;
  logic [LANES*PW-1:0] s1_prod;

  // whole pipe freezes while the output waits
  assign adv        = !(out_valid_o && !out_ready_i);
  assign in_ready_o = adv;
  assign accept     = in_valid_i && in_ready_o;

  pmu_decode i_dec (
    .opc_i  (opc_i),
    .legal_o(legal),
    .op_o   (dec_op)
  );

  pmu_mul_stage #(.LANES(LANES), .LW(LW)) i_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (adv),
    .load_i (accept && legal),
    .op_i   (dec_op),
    .a_i    (a_i),
    .b_i    (b_i),
    .valid_o(s1_valid),
    .op_o   (s1_op),
    .prod_o (s1_prod)
  );

  pmu_result_stage #(.LANES(LANES), .LW(LW)) i_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (adv),
    .valid_i(s1_valid),
    .op_i   (s1_op),
    .prod_i (s1_prod),
    .valid_o(out_valid_o),
    .data_o (out_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_o <= 1'b0;
    else         illegal_o <= accept && !legal;
  end

  a_r7_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
  a_r7_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);
  a_r5_no_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !legal |=> !s1_valid);
  a_r5_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(in_valid_i) && $past(in_ready_o));
  a_r6_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid && in_ready_o |=> out_valid_o);
endmodule

// File: tb/test_pmu_top.sv
module test_pmu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] opc = '0;
  logic [63:0] a = '0, b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        illegal;
  int          n_chk = 0, n_err = 0;
  logic [63:0] exp_q [8];
  logic [63:0] held;

  always #10 clk = ~clk;

  pmu_top i_pmu_top (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .opc_i(opc), .a_i(a), .b_i(b), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data), .illegal_o(illegal)
  );

  function automatic logic [15:0] opc_of(int m);
    case (m)
      0: return 16'h0FE5;
      1: return 16'h0FD5;
      default: return 16'h0FF5;
    endcase
  endfunction

  function automatic logic [63:0] model(int m, logic [63:0] x, logic [63:0] y);
    logic [63:0] r = '0;
    logic signed [31:0] p [4];
    for (int l = 0; l < 4; l++)
      p[l] = $signed(x[16*l +: 16]) * $signed(y[16*l +: 16]);
    for (int l = 0; l < 4; l++) begin
      if (m == 0) r[16*l +: 16] = p[l][31:16];
      else if (m == 1) r[16*l +: 16] = p[l][15:0];
    end
    if (m == 2) begin
      r[31:0]  = p[0] + p[1];
      r[63:32] = p[2] + p[3];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // one isolated transaction, output always ready
  task automatic run_one(string req, logic [15:0] o, logic [63:0] x, logic [63:0] y,
                         bit lgl, logic [63:0] expv);
    @(negedge clk);
    opc = o; a = x; b = y; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " illegal pulse"}, 64'(illegal), 64'(!lgl));
    chk({req, " R6 not early"}, 64'(out_valid), 64'd0);
    @(negedge clk);
    chk({req, " R6 valid at 2"}, 64'(out_valid), 64'(lgl));
    chk({req, " R5 pulse one cycle"}, 64'(illegal), 64'd0);
    if (lgl) chk(req, out_data, expv);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R8 out_valid", 64'(out_valid), 64'd0);
    chk("R8 illegal", 64'(illegal), 64'd0);
    chk("R8 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    // directed corners
    run_one("R1 hi neg", 16'h0FE5, 64'h8000_7FFF_FFFF_0002, 64'h8000_7FFF_0001_FFFD, 1,
            64'h4000_3FFF_FFFF_FFFF);
    run_one("R2 lo", 16'h0FD5, 64'hFFFF_1234_0100_0003, 64'hFFFF_0010_0100_0005, 1,
            64'h0001_2340_0000_000F);
    run_one("R3 mac", 16'h0FF5, 64'h0003_FFFE_0002_0001, 64'h0004_0005_0003_0002, 1,
            {32'd2, 32'd8});
    run_one("R4 wrap", 16'h0FF5, {4{16'h8000}}, {4{16'h8000}}, 1, 64'h80000000_80000000);
    run_one("R5 bad byte", 16'h0FA5, 64'h1, 64'h1, 0, '0);
    run_one("R5 bad prefix", 16'h0EE5, 64'h1, 64'h1, 0, '0);

    // R2 low half matches unsigned product
    for (int i = 0; i < 20; i++) begin
      logic [63:0] x = {$urandom, $urandom}, y = {$urandom, $urandom}, e;
      for (int l = 0; l < 4; l++) e[16*l +: 16] = 16'(32'(x[16*l +: 16]) * 32'(y[16*l +: 16]));
      run_one("R2 unsigned", 16'h0FD5, x, y, 1, e);
    end

    // random mix of all operations
    for (int i = 0; i < 150; i++) begin
      int m = int'($urandom_range(2, 0));
      logic [63:0] x = {$urandom, $urandom}, y = {$urandom, $urandom};
      run_one(m == 0 ? "R1 rnd" : (m == 1 ? "R2 rnd" : "R3 rnd"), opc_of(m), x, y, 1,
              model(m, x, y));
    end

    // R9 back-to-back stream
    begin
      int k = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (out_valid) begin
          if (k < 8) chk("R9 order", out_data, exp_q[k]);
          k++;
        end
        if (i < 8) begin
          int m = i % 3;
          logic [63:0] x = {$urandom, $urandom}, y = {$urandom, $urandom};
          chk("R9 ready", 64'(in_ready), 64'd1);
          opc = opc_of(m); a = x; b = y; in_valid = 1'b1;
          exp_q[i] = model(m, x, y);
        end else in_valid = 1'b0;
      end
      chk("R9 count", 64'(k), 64'd8);
    end

    // R7 stall
    @(negedge clk);
    out_ready = 1'b0;
    opc = 16'h0FE5; a = 64'h0100_0200_0300_0400; b = 64'h0100_0100_0100_0100; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 valid", 64'(out_valid), 64'd1);
    held = out_data;
    chk("R7 data", held, model(0, a, b));
    repeat (5) @(negedge clk);
    chk("R7 still valid", 64'(out_valid), 64'd1);
    chk("R7 stable", out_data, held);
    chk("R7 not ready", 64'(in_ready), 64'd0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R7 drained", 64'(out_valid), 64'd0);
    chk("R7 ready again", 64'(in_ready), 64'd1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule